// File: doc/BRIEF.md
# 8-bit ALU with Status Flags

This block is the arithmetic and logic unit of a small 8-bit processor core. It is purely combinational. It takes a register operand `opA`, which can be the accumulator or any other register the caller routes in, and a memory operand `opM`. It also takes the current status byte, whose bit 0 supplies the carry in, and a 4-bit operation code. It returns the operation result and an updated status byte. The status byte is unpacked into named flags, the N, V, Z and C fields are updated as the operation requires, and the byte is packed again. Every flag that the operation does not touch is carried through unchanged.

Arithmetic is binary only. Add and subtract detect signed overflow in two's complement. Compare and bit test update flags without changing the register. Shift and rotate, and increment and decrement, act on `opA`, so the caller routes either a register or a fetched memory byte into that port. The load operation passes `opM` to the result and sets Z and N from it, which also covers register transfers. The sequencer writes the result back wherever it chooses.

Top module: `alu8_core`

## Requirements
- R1: The status byte layout is: bit 0 C (carry), bit 1 Z (zero), bit 2 I (interrupt disable), bit 3 D (decimal), bit 4 B (break), bit 5 spare, bit 6 V (overflow), bit 7 N (negative). Bits 2 to 5 of `statusOut` always equal those of `statusIn`.
- R2: Code 0x0 (add) gives result = (A+M+C) mod 256. C is set when A+M+C > 0xFF. V is set when A and M have equal bit 7 and the result's bit 7 differs from A's.
- R3: Code 0x1 (subtract) gives result = (A−M−(1−C)) mod 256. C is set when A−M−(1−C) ≥ 0. V is set when A and M differ in bit 7 and the result's bit 7 differs from A's.
- R4: Code 0x2 (compare) returns A unchanged as the result. Z and N come from (A−M) mod 256, C is set when A ≥ M unsigned, and V is unchanged.
- R5: Codes 0x3 (AND), 0x4 (OR) and 0x5 (XOR) return the bitwise function of A and M. They update Z and N, and leave C and V unchanged.
- R6: Code 0x6 (bit test) returns A unchanged. Z is set when (A AND M) = 0, V takes M bit 6, N takes M bit 7, and C is unchanged.
- R7: Code 0x7 (shift left) returns (A<<1) mod 256 with bit 7 of A into C. Code 0x8 (shift right) returns A>>1 with a 0 into bit 7 and bit 0 of A into C. V is unchanged for both.
- R8: Code 0x9 (rotate left) returns (A<<1)|Cin with bit 7 of A into C. Code 0xA (rotate right) returns (A>>1)|(Cin<<7) with bit 0 of A into C. V is unchanged for both.
- R9: Code 0xB returns (A+1) mod 256, code 0xC returns (A−1) mod 256, and code 0xD (load) returns M. All three update only Z and N.
- R10: For every code from 0x0 to 0xD except 0x2 and 0x6, Z equals (result = 0) and N equals result bit 7.
- R11: Codes 0xE and 0xF return A and leave the status byte unchanged.
- R12: Flags that the selected operation does not update pass from `statusIn` to `statusOut` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | 8 | Register operand; also the operand of shift, rotate, increment and decrement |
| opM | input | 8 | Memory operand |
| statusIn | input | 8 | Current status byte; bit 0 is the carry in |
| opSel | input | 4 | Operation code |
| result | output | 8 | Operation result |
| statusOut | output | 8 | Updated status byte |

## Verification
The hardest cases to reach are the signed-overflow and borrow edges of subtract, where the carry in interacts with the sign of both operands. Examples are 0x80−0x00 with borrow pending and 0x00−0xFF with the carry clear. A random operand sweep rarely lands on these exactly. The stimulus therefore drives a directed list of sign and wrap boundaries for add, subtract and compare, each with both carry values, before a pseudo-random sweep over all sixteen codes. The random sweep also randomises the untouched status bits, so that pass-through of I, D, B and the spare bit is exercised.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  typedef enum logic [3:0] {
    OP_ADD   = 4'h0,
    OP_SUB   = 4'h1,
    OP_CMP   = 4'h2,
    OP_AND   = 4'h3,
    OP_OR    = 4'h4,
    OP_XOR   = 4'h5,
    OP_BIT   = 4'h6,
    OP_SHL   = 4'h7,
    OP_SHR   = 4'h8,
    OP_ROL   = 4'h9,
    OP_ROR   = 4'hA,
    OP_INC   = 4'hB,
    OP_DEC   = 4'hC,
    OP_LOAD  = 4'hD,
    OP_RSV_E = 4'hE,
    OP_RSV_F = 4'hF
  } aluOp_e;

  typedef enum logic [2:0] {
    SRC_PASS,
    SRC_ARITH,
    SRC_LOGIC,
    SRC_SHIFT,
    SRC_STEP,
    SRC_MEM
  } resSel_e;

  // strobes from control to datapath
  typedef struct packed {
    resSel_e    resSel;
    logic       writeBack;   // 0: result stays opA
    logic       subMode;     // invert memory operand
    logic       forceCarry;  // carry in forced to 1
    logic [1:0] logicFn;     // 0 and, 1 or, 2 xor
    logic [1:0] shiftFn;     // 0 shl, 1 shr, 2 rol, 3 ror
    logic       stepDown;
    logic       updNZ;
    logic       updC;
    logic       updV;
    logic       bitTest;
  } aluCtrl_t;

  typedef struct packed {
    logic neg;
    logic ovf;
    logic spare;
    logic brk;
    logic dec;
    logic irqOff;
    logic zero;
    logic carry;
  } status_t;

  function automatic status_t unpackStatus(input logic [7:0] b);
    status_t s;
    s.carry  = b[0];
    s.zero   = b[1];
    s.irqOff = b[2];
    s.dec    = b[3];
    s.brk    = b[4];
    s.spare  = b[5];
    s.ovf    = b[6];
    s.neg    = b[7];
    return s;
  endfunction

  function automatic logic [7:0] packStatus(input status_t s);
    return {s.neg, s.ovf, s.spare, s.brk, s.dec, s.irqOff, s.zero, s.carry};
  endfunction

endpackage

// File: rtl/alu8_ctrl.sv
module alu8_ctrl
  import alu8_pkg::*;
(
  input  logic [3:0] opSel,
  output aluCtrl_t   ctrl
);

  always_comb begin
    ctrl            = '0;
    ctrl.resSel     = SRC_PASS;
    ctrl.writeBack  = 1'b1;
    unique case (aluOp_e'(opSel))
      OP_ADD: begin
        ctrl.resSel = SRC_ARITH;
        ctrl.updNZ  = 1'b1; ctrl.updC = 1'b1; ctrl.updV = 1'b1;
      end
      OP_SUB: begin
        ctrl.resSel  = SRC_ARITH;
        ctrl.subMode = 1'b1;
        ctrl.updNZ   = 1'b1; ctrl.updC = 1'b1; ctrl.updV = 1'b1;
      end
      OP_CMP: begin
        ctrl.resSel     = SRC_ARITH;
        ctrl.subMode    = 1'b1;
        ctrl.forceCarry = 1'b1;
        ctrl.writeBack  = 1'b0;
        ctrl.updNZ      = 1'b1; ctrl.updC = 1'b1;
      end
      OP_AND, OP_OR, OP_XOR: begin
        ctrl.resSel  = SRC_LOGIC;
        ctrl.logicFn = opSel[1:0] - 2'd3;
        ctrl.updNZ   = 1'b1;
      end
      OP_BIT: begin
        ctrl.resSel    = SRC_LOGIC;
        ctrl.logicFn   = 2'd0;
        ctrl.writeBack = 1'b0;
        ctrl.bitTest   = 1'b1;
        ctrl.updNZ     = 1'b1; ctrl.updV = 1'b1;
      end
      OP_SHL, OP_SHR, OP_ROL, OP_ROR: begin
        ctrl.resSel  = SRC_SHIFT;
        ctrl.shiftFn = opSel[1:0] + 2'd1;
        ctrl.updNZ   = 1'b1; ctrl.updC = 1'b1;
      end
      OP_INC, OP_DEC: begin
        ctrl.resSel   = SRC_STEP;
        ctrl.stepDown = (opSel == OP_DEC);
        ctrl.updNZ    = 1'b1;
      end
      OP_LOAD: begin
        ctrl.resSel = SRC_MEM;
        ctrl.updNZ  = 1'b1;
      end
      default: ctrl.writeBack = 1'b0;
    endcase
  end

endmodule

// File: rtl/alu8_dp.sv
module alu8_dp
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
)(
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opM,
  input  logic [7:0]        statusIn,
  input  aluCtrl_t          ctrl,
  output logic [DATA_W-1:0] result,
  output logic [7:0]        statusOut
);

  localparam int MSB = DATA_W - 1;

  status_t flagsIn, flagsNext;
  logic [DATA_W-1:0] addB, arithVal, logicVal, shiftVal, stepVal, selVal, nzSrc;
  logic [DATA_W:0]   sumFull;
  logic              cinArith, arithCarry, arithOvf, shiftCarry;

  assign flagsIn  = unpackStatus(statusIn);

  // shared adder: add, subtract and compare
  assign addB     = ctrl.subMode ? ~opM : opM;
  assign cinArith = ctrl.forceCarry | flagsIn.carry;
  assign sumFull  = {1'b0, opA} + {1'b0, addB} + {{DATA_W{1'b0}}, cinArith};
  assign arithVal = sumFull[MSB:0];
  assign arithCarry = sumFull[DATA_W];
  assign arithOvf = (opA[MSB] == addB[MSB]) && (arithVal[MSB] != opA[MSB]);

  always_comb begin
    unique case (ctrl.logicFn)
      2'd1:    logicVal = opA | opM;
      2'd2:    logicVal = opA ^ opM;
      default: logicVal = opA & opM;
    endcase
  end

  always_comb begin
    unique case (ctrl.shiftFn)
      2'd0: begin shiftVal = {opA[MSB-1:0], 1'b0};          shiftCarry = opA[MSB]; end
      2'd1: begin shiftVal = {1'b0, opA[MSB:1]};            shiftCarry = opA[0];   end
      2'd2: begin shiftVal = {opA[MSB-1:0], flagsIn.carry}; shiftCarry = opA[MSB]; end
      default: begin shiftVal = {flagsIn.carry, opA[MSB:1]}; shiftCarry = opA[0]; end
    endcase
  end

  assign stepVal = ctrl.stepDown ? opA - {{(DATA_W-1){1'b0}}, 1'b1}
                                 : opA + {{(DATA_W-1){1'b0}}, 1'b1};

  always_comb begin
    unique case (ctrl.resSel)
      SRC_ARITH: selVal = arithVal;
      SRC_LOGIC: selVal = logicVal;
      SRC_SHIFT: selVal = shiftVal;
      SRC_STEP:  selVal = stepVal;
      SRC_MEM:   selVal = opM;
      default:   selVal = opA;
    endcase
  end

  assign result = ctrl.writeBack ? selVal : opA;
  assign nzSrc  = selVal;

  always_comb begin
    flagsNext = flagsIn;
    if (ctrl.updNZ) begin
      flagsNext.zero = (nzSrc == '0);
      flagsNext.neg  = ctrl.bitTest ? opM[MSB] : nzSrc[MSB];
    end
    if (ctrl.updC)
      flagsNext.carry = (ctrl.resSel == SRC_ARITH) ? arithCarry : shiftCarry;
    if (ctrl.updV)
      flagsNext.ovf = ctrl.bitTest ? opM[MSB-1] : arithOvf;
  end

  assign statusOut = packStatus(flagsNext);

  // R6: bit test copies operand bits into N and V, keeps carry
  always_comb begin
    if (ctrl.bitTest)
      a_r6_bit_copy: assert (statusOut[7] == opM[MSB] && statusOut[6] == opM[MSB-1]
                             && statusOut[0] == statusIn[0]);
  end

  // R1: control and spare bits untouched by the datapath
  always_comb begin
    a_r1_fixed_bits: assert (statusOut[5:2] == statusIn[5:2]);
  end

endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
)(
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opM,
  input  logic [7:0]        statusIn,
  input  logic [3:0]        opSel,
  output logic [DATA_W-1:0] result,
  output logic [7:0]        statusOut
);

  localparam int MSB = DATA_W - 1;

  aluCtrl_t ctrl;

  alu8_ctrl u_ctrl (
    .opSel (opSel),
    .ctrl  (ctrl)
  );

  alu8_dp #(.DATA_W(DATA_W)) u_dp (
    .opA       (opA),
    .opM       (opM),
    .statusIn  (statusIn),
    .ctrl      (ctrl),
    .result    (result),
    .statusOut (statusOut)
  );

  logic [DATA_W:0] addRef;
  assign addRef = {1'b0, opA} + {1'b0, opM} + {{DATA_W{1'b0}}, statusIn[0]};

  // R2: carry and result together form the true sum
  always_comb begin
    if (opSel == OP_ADD)
      a_r2_add_sum: assert ({statusOut[0], result} == addRef);
  end

  // R4: compare leaves the register and V alone
  always_comb begin
    if (opSel == OP_CMP)
      a_r4_cmp_keeps: assert (result == opA && statusOut[6] == statusIn[6]);
  end

  // R11: reserved codes are full pass-through
  always_comb begin
    if (opSel == OP_RSV_E || opSel == OP_RSV_F)
      a_r11_unused_pass: assert (result == opA && statusOut == statusIn);
  end

  // R10: Z and N follow the written-back result
  always_comb begin
    if (opSel <= OP_LOAD && opSel != OP_CMP && opSel != OP_BIT)
      a_r10_zn_follow: assert (statusOut[1] == (result == '0) && statusOut[7] == result[MSB]);
  end

  // R12: carry kept by logic, step and load operations
  always_comb begin
    if ((opSel >= OP_AND && opSel <= OP_BIT) || opSel >= OP_INC)
      a_r12_carry_kept: assert (statusOut[0] == statusIn[0]);
  end

endmodule

// File: tb/tb_alu8_core.sv
module tb_alu8_core;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rstN;
  logic [7:0] opA, opM, statusIn, result, statusOut;
  logic [3:0] opSel;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;
  logic [31:0] lfsr = 32'h1D2C_3B4A;

  alu8_core dut (
    .opA       (opA),
    .opM       (opM),
    .statusIn  (statusIn),
    .opSel     (opSel),
    .result    (result),
    .statusOut (statusOut)
  );

  function automatic int setBit(int val, int pos, bit b);
    return b ? (val | (1 << pos)) : (val & ~(1 << pos));
  endfunction

  function automatic string tagOf(int op);
    case (op)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3, 4, 5: return "R5";
      6: return "R6";
      7, 8: return "R7";
      9, 10: return "R8";
      11, 12, 13: return "R9";
      default: return "R11";
    endcase
  endfunction

  // behavioural reference
  task automatic refModel(input int op, input int a, input int m, input int s,
                          output int r, output int so);
    int c, t, nzv;
    bit updNZ;
    c = s & 1; so = s; r = a; updNZ = 0; nzv = 0;
    case (op)
      0: begin
        t = a + m + c; r = t % 256;
        so = setBit(so, 0, t > 255);
        so = setBit(so, 6, ((a ^ m) & 128) == 0 && ((a ^ r) & 128) != 0);
        updNZ = 1; nzv = r;
      end
      1: begin
        t = a - m - (1 - c); r = (t + 512) % 256;
        so = setBit(so, 0, t >= 0);
        so = setBit(so, 6, ((a ^ m) & 128) != 0 && ((a ^ r) & 128) != 0);
        updNZ = 1; nzv = r;
      end
      2: begin
        so = setBit(so, 0, a >= m);
        updNZ = 1; nzv = (a - m + 256) % 256;
      end
      3: begin r = a & m; updNZ = 1; nzv = r; end
      4: begin r = a | m; updNZ = 1; nzv = r; end
      5: begin r = a ^ m; updNZ = 1; nzv = r; end
      6: begin
        so = setBit(so, 1, (a & m) == 0);
        so = setBit(so, 7, ((m >> 7) & 1) == 1);
        so = setBit(so, 6, ((m >> 6) & 1) == 1);
      end
      7:  begin r = (a * 2) % 256;       so = setBit(so, 0, a >= 128); updNZ = 1; nzv = r; end
      8:  begin r = a / 2;               so = setBit(so, 0, (a % 2) == 1); updNZ = 1; nzv = r; end
      9:  begin r = (a * 2) % 256 + c;   so = setBit(so, 0, a >= 128); updNZ = 1; nzv = r; end
      10: begin r = a / 2 + c * 128;    so = setBit(so, 0, (a % 2) == 1); updNZ = 1; nzv = r; end
      11: begin r = (a + 1) % 256;   updNZ = 1; nzv = r; end
      12: begin r = (a + 255) % 256; updNZ = 1; nzv = r; end
      13: begin r = m;               updNZ = 1; nzv = r; end
      default: ;
    endcase
    if (updNZ) begin
      so = setBit(so, 1, nzv == 0);
      so = setBit(so, 7, nzv >= 128);
    end
  endtask

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (op %0h a %0h m %0h s %0h)",
               tag, act, exp, opSel, opA, opM, statusIn);
    end
  endtask

  task automatic apply(input int op, input int a, input int m, input int s);
    int expR, expS;
    @(posedge clk);
    #1;
    opSel = op[3:0]; opA = a[7:0]; opM = m[7:0]; statusIn = s[7:0];
    @(negedge clk);
    refModel(op, a & 255, m & 255, s & 255, expR, expS);
    check({tagOf(op), " result"}, int'(result), expR);
    check({tagOf(op), " status"}, int'(statusOut), expS);
    check("R1 fixed bits", int'(statusOut[5:2]), (s >> 2) & 15);
    if ((op >= 3 && op <= 6) || op >= 11)
      check("R12 carry kept", int'(statusOut[0]), s & 1);
    if (op != 2 && op != 6 && op <= 13) begin
      check("R10 zero", int'(statusOut[1]), int'(expR == 0));
      check("R10 negative", int'(statusOut[7]), (expR >> 7) & 1);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    rstN = 1'b0;
    opSel = 4'h0; opA = 8'h00; opM = 8'h00; statusIn = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // initial state: zero add gives zero result with Z set (R2, R10)
    check("R2 initial result", int'(result), 0);
    check("R10 initial status", int'(statusOut), 8'h02);
    rstN = 1'b1;

    // R2 add: carry, signed overflow both ways
    apply(0, 8'h7F, 8'h01, 8'h00);
    apply(0, 8'h80, 8'h80, 8'h00);
    apply(0, 8'hFF, 8'h00, 8'h01);
    apply(0, 8'h50, 8'h2F, 8'h01);
    apply(0, 8'hC0, 8'h40, 8'h3C);
    // R3 subtract: borrow and overflow edges
    apply(1, 8'h80, 8'h00, 8'h00);
    apply(1, 8'h00, 8'hFF, 8'h00);
    apply(1, 8'h00, 8'h00, 8'h00);
    apply(1, 8'h00, 8'h00, 8'h01);
    apply(1, 8'h7F, 8'hFF, 8'h01);
    apply(1, 8'h80, 8'h01, 8'h01);
    // R4 compare: equal, below, above
    apply(2, 8'h42, 8'h42, 8'h40);
    apply(2, 8'h10, 8'h20, 8'h41);
    apply(2, 8'hF0, 8'h01, 8'h00);
    // R5 logic
    apply(3, 8'hF0, 8'h0F, 8'hC1);
    apply(4, 8'h80, 8'h01, 8'h01);
    apply(5, 8'hAA, 8'hAA, 8'h40);
    // R6 bit test
    apply(6, 8'h01, 8'hC0, 8'h01);
    apply(6, 8'hFF, 8'h3F, 8'hC2);
    // R7 shifts
    apply(7, 8'h80, 8'h00, 8'h00);
    apply(8, 8'h01, 8'h00, 8'h80);
    // R8 rotates with carry in set and clear
    apply(9, 8'h80, 8'h00, 8'h01);
    apply(9, 8'h40, 8'h00, 8'h00);
    apply(10, 8'h01, 8'h00, 8'h01);
    apply(10, 8'h02, 8'h00, 8'h00);
    // R9 step and load wraps
    apply(11, 8'hFF, 8'h00, 8'h41);
    apply(12, 8'h00, 8'h00, 8'h00);
    apply(12, 8'h01, 8'h00, 8'h80);
    apply(13, 8'h12, 8'h80, 8'h02);
    apply(13, 8'h12, 8'h00, 8'h80);
    // R11 reserved codes
    apply(14, 8'h5A, 8'hA5, 8'hFF);
    apply(15, 8'h00, 8'hFF, 8'h24);

    // sweep over all codes, random operands and status
    for (int i = 0; i < 4000; i++) begin
      for (int k = 0; k < 32; k++)
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      apply(i % 16, int'(lfsr[7:0]), int'(lfsr[15:8]), int'(lfsr[23:16]));
    end

    finishRun();
  end

endmodule